// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block sits between a host register bus and an embedded I/O processor. The host sees a small map of 32-bit registers: two message registers in each direction, a doorbell, interrupt status and mask registers in each direction, and two queue ports. Each queue port is one address that hides a hardware FIFO. Reading the inbound port takes a free request frame offset from the free-frame FIFO. Writing the inbound port posts a request entry to the device. Reading the outbound port takes the next completion. Writing the outbound port hands a device-memory frame back to the free-frame pool.

A posted entry with bit 31 set names a request in host memory. Such requests are 32-byte aligned, so bits 30:0 carry the bus address shifted right by five. The device side receives this entry with the flag and the rebuilt byte address already split out. The device uses valid/ready streams to do three things: seed the free pool, consume posted requests and push completions. A stream moves a word only in a cycle where valid and ready are both high. The producer must hold valid and data steady until that cycle.

Three cases apply back-pressure:
- A full FIFO drops its ready.
- When the host returns a frame, it takes the free-pool write slot, so the device seed stream sees ready low in that cycle.
- A host write to a full inbound port is discarded.

Non-queued commands go through message register 0. The device signals completion by writing the same value to outbound message 0. One host interrupt line and one device-facing interrupt line summarise the unmasked status bits of each direction.

Top module: `qport_msg_unit`

## Requirements
- R1: After reset, hst_rdata, hst_irq, dev_irq, post_valid and every host-readable register read as 0, and the doorbell is 0.
- R2: A host read of address 0x40 returns the oldest free-frame entry and removes it. Entries come out in arrival order. If the free-frame FIFO is empty, the read returns 0xFFFFFFFF and removes nothing. Read data appears on hst_rdata in the cycle after hst_rd.
- R3: A host write to 0x40 appends the value to the posted FIFO, which the device drains in order through post_valid/post_ready. post_is_host equals bit 31 of the entry, and post_host_addr equals bits 30:0 shifted left by 5.
- R4: A word accepted on the cpl stream is returned, in order, by host reads of 0x44. If the completion FIFO is empty, the read returns 0xFFFFFFFF.
- R5: A host write to 0x44 appends the value to the free-frame FIFO. In that cycle ff_in_ready is low, so the host write wins over a device seed word.
- R6: A host write to 0x10 or 0x14 updates imsg0 or imsg1, reads back at the same address, and sets inbound status bit 0 or bit 1. A device write with dev_omsg_sel 0 or 1 updates the value read at 0x18 or 0x1C and sets outbound status bit 0 or bit 1.
- R7: Status registers are at 0x24 (inbound) and 0x30 (outbound). Writing 1 to a sticky status bit clears it. The mask registers are at 0x28 and 0x34, bits 2:0. A set mask bit keeps the matching status bit off the line. dev_irq is the OR of the unmasked inbound status bits, and hst_irq is the OR of the unmasked outbound status bits.
- R8: Outbound status bit 2 is high exactly while the completion FIFO holds an entry. Writing 1 to it has no effect.
- R9: A host write to 0x20 ORs the value into the doorbell. A 1 on dev_db_clr clears the matching doorbell bit. Inbound status bit 2 is high while the doorbell is nonzero.
- R10: A FIFO never holds more than its depth. When the posted FIFO is full, a further host write to 0x40 is dropped and the earlier entries are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 8 | Host register byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after hst_rd |
| hst_irq | output | 1 | Host interrupt line |
| ff_in_valid | input | 1 | Device seeds a free frame offset |
| ff_in_ready | output | 1 | Free-frame FIFO accepts a seed word |
| ff_in_data | input | 32 | Free frame offset |
| post_valid | output | 1 | Posted request entry available |
| post_ready | input | 1 | Device takes the posted entry |
| post_data | output | 32 | Raw posted entry |
| post_is_host | output | 1 | Entry refers to host memory (bit 31) |
| post_host_addr | output | 36 | Host byte address rebuilt from bits 30:0 |
| cpl_valid | input | 1 | Device offers a completion |
| cpl_ready | output | 1 | Completion FIFO accepts |
| cpl_data | input | 32 | Completion value |
| imsg0 | output | 32 | Inbound message 0 |
| imsg1 | output | 32 | Inbound message 1 |
| dev_omsg_we | input | 1 | Device writes an outbound message |
| dev_omsg_sel | input | 1 | Selects outbound message 0 or 1 |
| dev_omsg_data | input | 32 | Outbound message value |
| doorbell | output | 32 | Doorbell bits |
| dev_db_clr | input | 32 | Device doorbell clear bits |
| dev_irq | output | 1 | Device-facing inbound interrupt |

## Verification
The hardest situation to reach is a collision on the free-frame FIFO. The host returns a frame through 0x44 in the same cycle the device offers a seed word. The bench holds ff_in_valid across a host write to 0x44, confirms ready is low in that cycle, and confirms both words then come out of 0x40 with the host's first. A full posted FIFO also takes deliberate setup: the bench holds post_ready low through seventeen inbound-port writes, then drains the FIFO and checks that exactly sixteen entries come out in order.

// File: rtl/qpm_pkg.sv
package qpm_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  localparam logic [AW-1:0] ADR_IMSG0 = 8'h10;
  localparam logic [AW-1:0] ADR_IMSG1 = 8'h14;
  localparam logic [AW-1:0] ADR_OMSG0 = 8'h18;
  localparam logic [AW-1:0] ADR_OMSG1 = 8'h1C;
  localparam logic [AW-1:0] ADR_DBELL = 8'h20;
  localparam logic [AW-1:0] ADR_ISTAT = 8'h24;
  localparam logic [AW-1:0] ADR_IMASK = 8'h28;
  localparam logic [AW-1:0] ADR_OSTAT = 8'h30;
  localparam logic [AW-1:0] ADR_OMASK = 8'h34;
  localparam logic [AW-1:0] ADR_QIN   = 8'h40;
  localparam logic [AW-1:0] ADR_QOUT  = 8'h44;

  localparam int NSTAT = 3;
  localparam int SB_MSG0  = 0;
  localparam int SB_MSG1  = 1;
  localparam int SB_LEVEL = 2;

  localparam int ALIGN_SH = 5;
  localparam logic [DW-1:0] EMPTY_WORD = '1;
endpackage

// File: rtl/qpm_fifo.sv
module qpm_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_data,
  output logic             pop_valid,
  input  logic             pop_ready,
  output logic [WIDTH-1:0] pop_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic do_push, do_pop;

  assign push_ready = (count != FULL);
  assign pop_valid  = (count != '0);
  assign pop_data   = mem[rd_ptr];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R10
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> count == $past(count) + 1'b1); // R2
endmodule

// File: rtl/qpm_irq.sv
module qpm_irq #(
  parameter int N = 3,
  parameter logic [N-1:0] LEVEL_BITS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] level_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_bits,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    if (LEVEL_BITS[b]) begin : g_level
      assign status_o[b] = level_i[b];
    end else begin : g_sticky
      logic st_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              st_q <= 1'b0;
        else if (set_i[b])       st_q <= 1'b1;
        else if (clr_we && clr_bits[b]) st_q <= 1'b0;
      end
      assign status_o[b] = st_q;

      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_bits[b] && !set_i[b]) |=> !status_o[b]); // R7
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_o <= '0;
    else if (mask_we) mask_o <= mask_bits;
  end

  assign irq_o = |(status_o & ~mask_o);
endmodule

// File: rtl/qport_msg_unit.sv
module qport_msg_unit
  import qpm_pkg::*;
#(
  parameter int FREE_DEPTH = 16,
  parameter int POST_DEPTH = 16,
  parameter int CPL_DEPTH  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          hst_irq,
  input  logic          ff_in_valid,
  output logic          ff_in_ready,
  input  logic [DW-1:0] ff_in_data,
  output logic          post_valid,
  input  logic          post_ready,
  output logic [DW-1:0] post_data,
  output logic          post_is_host,
  output logic [DW+ALIGN_SH-2:0] post_host_addr,
  input  logic          cpl_valid,
  output logic          cpl_ready,
  input  logic [DW-1:0] cpl_data,
  output logic [DW-1:0] imsg0,
  output logic [DW-1:0] imsg1,
  input  logic          dev_omsg_we,
  input  logic          dev_omsg_sel,
  input  logic [DW-1:0] dev_omsg_data,
  output logic [DW-1:0] doorbell,
  input  logic [DW-1:0] dev_db_clr,
  output logic          dev_irq
);
  localparam logic [NSTAT-1:0] LVL = NSTAT'(1 << SB_LEVEL);

  logic wr_hit_qin, wr_hit_qout, rd_hit_qin, rd_hit_qout;
  assign wr_hit_qin  = hst_wr && (hst_addr == ADR_QIN);
  assign wr_hit_qout = hst_wr && (hst_addr == ADR_QOUT);
  assign rd_hit_qin  = hst_rd && (hst_addr == ADR_QIN);
  assign rd_hit_qout = hst_rd && (hst_addr == ADR_QOUT);

  // free-frame pool: host returns win the write slot over device seeds
  logic          ff_push_valid, ff_push_ready, ff_pop_valid;
  logic [DW-1:0] ff_push_data, ff_head;
  assign ff_push_valid = wr_hit_qout || ff_in_valid;
  assign ff_push_data  = wr_hit_qout ? hst_wdata : ff_in_data;
  assign ff_in_ready   = ff_push_ready && !wr_hit_qout;

  qpm_fifo #(.WIDTH(DW), .DEPTH(FREE_DEPTH)) u_free (
    .clk, .rst_n,
    .push_valid(ff_push_valid), .push_ready(ff_push_ready), .push_data(ff_push_data),
    .pop_valid(ff_pop_valid), .pop_ready(rd_hit_qin), .pop_data(ff_head)
  );

  logic post_push_ready;
  qpm_fifo #(.WIDTH(DW), .DEPTH(POST_DEPTH)) u_post (
    .clk, .rst_n,
    .push_valid(wr_hit_qin), .push_ready(post_push_ready), .push_data(hst_wdata),
    .pop_valid(post_valid), .pop_ready(post_ready), .pop_data(post_data)
  );
  assign post_is_host   = post_data[DW-1];
  assign post_host_addr = {post_data[DW-2:0], {ALIGN_SH{1'b0}}};

  logic          cpl_pop_valid;
  logic [DW-1:0] cpl_head;
  qpm_fifo #(.WIDTH(DW), .DEPTH(CPL_DEPTH)) u_cpl (
    .clk, .rst_n,
    .push_valid(cpl_valid), .push_ready(cpl_ready), .push_data(cpl_data),
    .pop_valid(cpl_pop_valid), .pop_ready(rd_hit_qout), .pop_data(cpl_head)
  );

  // message and doorbell registers
  logic [DW-1:0] imsg0_q, imsg1_q, omsg0_q, omsg1_q, db_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imsg0_q <= '0; imsg1_q <= '0; omsg0_q <= '0; omsg1_q <= '0; db_q <= '0;
    end else begin
      if (hst_wr && hst_addr == ADR_IMSG0) imsg0_q <= hst_wdata;
      if (hst_wr && hst_addr == ADR_IMSG1) imsg1_q <= hst_wdata;
      if (dev_omsg_we && !dev_omsg_sel)    omsg0_q <= dev_omsg_data;
      if (dev_omsg_we &&  dev_omsg_sel)    omsg1_q <= dev_omsg_data;
      db_q <= (db_q & ~dev_db_clr) |
              ((hst_wr && hst_addr == ADR_DBELL) ? hst_wdata : '0);
    end
  end
  assign imsg0    = imsg0_q;
  assign imsg1    = imsg1_q;
  assign doorbell = db_q;

  // interrupt status per direction
  logic [NSTAT-1:0] in_set, in_lvl, out_set, out_lvl;
  logic [NSTAT-1:0] in_stat, in_mask, out_stat, out_mask;
  always_comb begin
    in_set  = '0; in_lvl = '0; out_set = '0; out_lvl = '0;
    in_set[SB_MSG0]   = hst_wr && hst_addr == ADR_IMSG0;
    in_set[SB_MSG1]   = hst_wr && hst_addr == ADR_IMSG1;
    in_lvl[SB_LEVEL]  = |db_q;
    out_set[SB_MSG0]  = dev_omsg_we && !dev_omsg_sel;
    out_set[SB_MSG1]  = dev_omsg_we &&  dev_omsg_sel;
    out_lvl[SB_LEVEL] = cpl_pop_valid;
  end

  qpm_irq #(.N(NSTAT), .LEVEL_BITS(LVL)) u_in_irq (
    .clk, .rst_n, .set_i(in_set), .level_i(in_lvl),
    .clr_we(hst_wr && hst_addr == ADR_ISTAT), .clr_bits(hst_wdata[NSTAT-1:0]),
    .mask_we(hst_wr && hst_addr == ADR_IMASK), .mask_bits(hst_wdata[NSTAT-1:0]),
    .status_o(in_stat), .mask_o(in_mask), .irq_o(dev_irq)
  );

  qpm_irq #(.N(NSTAT), .LEVEL_BITS(LVL)) u_out_irq (
    .clk, .rst_n, .set_i(out_set), .level_i(out_lvl),
    .clr_we(hst_wr && hst_addr == ADR_OSTAT), .clr_bits(hst_wdata[NSTAT-1:0]),
    .mask_we(hst_wr && hst_addr == ADR_OMASK), .mask_bits(hst_wdata[NSTAT-1:0]),
    .status_o(out_stat), .mask_o(out_mask), .irq_o(hst_irq)
  );

  // registered read path; queue pops take effect on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst_rdata <= '0;
    end else if (hst_rd) begin
      case (hst_addr)
        ADR_IMSG0: hst_rdata <= imsg0_q;
        ADR_IMSG1: hst_rdata <= imsg1_q;
        ADR_OMSG0: hst_rdata <= omsg0_q;
        ADR_OMSG1: hst_rdata <= omsg1_q;
        ADR_DBELL: hst_rdata <= db_q;
        ADR_ISTAT: hst_rdata <= DW'(in_stat);
        ADR_IMASK: hst_rdata <= DW'(in_mask);
        ADR_OSTAT: hst_rdata <= DW'(out_stat);
        ADR_OMASK: hst_rdata <= DW'(out_mask);
        ADR_QIN:   hst_rdata <= ff_pop_valid  ? ff_head  : EMPTY_WORD;
        ADR_QOUT:  hst_rdata <= cpl_pop_valid ? cpl_head : EMPTY_WORD;
        default:   hst_rdata <= '0;
      endcase
    end
  end

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_qin && !ff_pop_valid) |=> hst_rdata == EMPTY_WORD); // R2
  AST_DB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hst_wr && hst_addr == ADR_DBELL) && dev_db_clr == '0) |=> $stable(doorbell)); // R9
  AST_OMSG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_omsg_we && !dev_omsg_sel) |=> out_stat[SB_MSG0]); // R6
  AST_POST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_qin && !post_push_ready && !post_ready) |=> $stable(post_data)); // R10
endmodule

// File: tb/qport_msg_unit_test.sv
module qport_msg_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1;

  // {op, addr, data, expected read}
  localparam logic [73:0] VEC [NV] = '{
    {OP_RD, 8'h10, 32'h0,          32'h0},
    {OP_WR, 8'h10, 32'hCAFE0001,   32'h0},
    {OP_RD, 8'h10, 32'h0,          32'hCAFE0001},
    {OP_RD, 8'h24, 32'h0,          32'h1},
    {OP_WR, 8'h24, 32'h1,          32'h0},
    {OP_RD, 8'h24, 32'h0,          32'h0},
    {OP_WR, 8'h20, 32'hF0,         32'h0},
    {OP_WR, 8'h20, 32'h03,         32'h0},
    {OP_RD, 8'h20, 32'h0,          32'hF3},
    {OP_RD, 8'h24, 32'h0,          32'h4},
    {OP_WR, 8'h34, 32'h7,          32'h0},
    {OP_RD, 8'h34, 32'h0,          32'h7},
    {OP_WR, 8'h34, 32'h0,          32'h0},
    {OP_RD, 8'h40, 32'h0,          32'hFFFFFFFF},
    {OP_RD, 8'h44, 32'h0,          32'hFFFFFFFF},
    {OP_WR, 8'h14, 32'h1234,       32'h0},
    {OP_RD, 8'h14, 32'h0,          32'h1234},
    {OP_RD, 8'h24, 32'h0,          32'h6}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_rd = 0, hst_wr = 0;
  logic [7:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0, hst_rdata;
  logic hst_irq, ff_in_valid = 0, ff_in_ready;
  logic [31:0] ff_in_data = 0;
  logic post_valid, post_ready = 0, post_is_host;
  logic [31:0] post_data;
  logic [35:0] post_host_addr;
  logic cpl_valid = 0, cpl_ready;
  logic [31:0] cpl_data = 0, imsg0, imsg1;
  logic dev_omsg_we = 0, dev_omsg_sel = 0;
  logic [31:0] dev_omsg_data = 0, doorbell, dev_db_clr = 0;
  logic dev_irq;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qport_msg_unit uut (.*);

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); hst_rd = 1; hst_addr = a;
    @(negedge clk); hst_rd = 0; d = hst_rdata;
  endtask

  task automatic dseed(input logic [31:0] d);
    @(negedge clk); ff_in_valid = 1; ff_in_data = d;
    @(negedge clk); ff_in_valid = 0;
  endtask

  task automatic dcpl(input logic [31:0] d);
    @(negedge clk); cpl_valid = 1; cpl_data = d;
    @(negedge clk); cpl_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 hst_irq", hst_irq, 0);
    check("R1 dev_irq", dev_irq, 0);
    check("R1 post_valid", post_valid, 0);
    check("R1 doorbell", doorbell, 0);
    check("R1 rdata", hst_rdata, 0);
    hrd(8'h30, r); check("R1 ostat", r, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][73:72] == OP_WR) hwr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        hrd(VEC[i][71:64], r);
        check($sformatf("R2 R4 R6 R7 R9 table vector %0d", i), r, VEC[i][31:0]);
      end
    end
    check("R7 dev_irq unmasked", dev_irq, 1);
    check("R7 hst_irq idle", hst_irq, 0);

    // R9 device clears doorbell bits
    @(negedge clk); dev_db_clr = 32'hF0; @(negedge clk); dev_db_clr = 0;
    hrd(8'h20, r); check("R9 partial clear", r, 32'h3);
    @(negedge clk); dev_db_clr = 32'h3; @(negedge clk); dev_db_clr = 0;
    hrd(8'h24, r); check("R9 level bit drops", r, 32'h2);
    hwr(8'h24, 32'h2);
    check("R7 dev_irq cleared", dev_irq, 0);

    // R2 free-frame order and empty read
    dseed(32'h100); dseed(32'h200);
    hrd(8'h40, r); check("R2 first frame", r, 32'h100);
    hrd(8'h40, r); check("R2 second frame", r, 32'h200);
    hrd(8'h40, r); check("R2 empty", r, 32'hFFFFFFFF);

    // R5 host return collides with device seed
    @(negedge clk); hst_wr = 1; hst_addr = 8'h44; hst_wdata = 32'h300;
    ff_in_valid = 1; ff_in_data = 32'h400;
    #1 check("R5 seed blocked", ff_in_ready, 0);
    @(negedge clk); hst_wr = 0;
    #1 check("R5 seed ready again", ff_in_ready, 1);
    @(negedge clk); ff_in_valid = 0;
    hrd(8'h40, r); check("R5 host frame first", r, 32'h300);
    hrd(8'h40, r); check("R5 seed second", r, 32'h400);

    // R3 posted entries and host-memory encoding
    hwr(8'h40, 32'h8000_0010);
    hwr(8'h40, 32'h0000_1000);
    check("R3 valid", post_valid, 1);
    check("R3 data", post_data, 32'h8000_0010);
    check("R3 host flag", post_is_host, 1);
    check("R3 host addr", post_host_addr, 36'h200);
    post_ready = 1; @(negedge clk);
    check("R3 second data", post_data, 32'h1000);
    check("R3 device flag", post_is_host, 0);
    @(negedge clk); post_ready = 0;
    check("R3 drained", post_valid, 0);

    // R4 R8 R7 completion path
    dcpl(32'hAA); dcpl(32'hBB);
    check("R8 hst_irq on completion", hst_irq, 1);
    hwr(8'h30, 32'h4);
    hrd(8'h30, r); check("R8 W1C ignored", r, 32'h4);
    hwr(8'h34, 32'h4);
    check("R7 masked", hst_irq, 0);
    hwr(8'h34, 32'h0);
    hrd(8'h44, r); check("R4 first cpl", r, 32'hAA);
    hrd(8'h44, r); check("R4 second cpl", r, 32'hBB);
    hrd(8'h30, r); check("R8 cleared when empty", r, 0);
    hrd(8'h44, r); check("R4 empty", r, 32'hFFFFFFFF);
    check("R7 hst_irq low", hst_irq, 0);

    // R6 message completion
    @(negedge clk); dev_omsg_we = 1; dev_omsg_sel = 0; dev_omsg_data = 32'hCAFE0001;
    @(negedge clk); dev_omsg_we = 0;
    check("R6 hst_irq", hst_irq, 1);
    hrd(8'h18, r); check("R6 omsg0", r, 32'hCAFE0001);
    hrd(8'h30, r); check("R6 ostat bit0", r, 32'h1);
    hwr(8'h30, 32'h1);
    check("R7 W1C clears", hst_irq, 0);
    @(negedge clk); dev_omsg_we = 1; dev_omsg_sel = 1; dev_omsg_data = 32'h55;
    @(negedge clk); dev_omsg_we = 0;
    hrd(8'h1C, r); check("R6 omsg1", r, 32'h55);
    hrd(8'h30, r); check("R6 ostat bit1", r, 32'h2);

    // R10 posted FIFO full drop
    for (int i = 0; i < 17; i++) hwr(8'h40, 32'h50 + i);
    post_ready = 1;
    for (int i = 0; i < 16; i++) begin
      check($sformatf("R10 drain %0d", i), {post_valid, post_data}, {1'b1, 32'h50 + i});
      @(negedge clk);
    end
    post_ready = 0;
    check("R10 extra dropped", post_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule